// File: doc/BRIEF.md
# RISC Instruction Decode and Execute Stage

This block is the execute stage of a 32-bit load/store RISC pipeline. Each cycle it can accept one instruction word with the values of the two source registers that the word names. It splits the word into its register-form or immediate-form fields and picks an arithmetic, logical, compare or shift operation. Operand B comes either from the second register or from the 16-bit immediate, extended or placed as the operation requires. One clock edge later the stage presents the result, the destination register index and a write enable for the register file.

The supported set is add, sub, and, or, nor, slt, sll and srl in register form, and addi, andi, ori and lui in immediate form. Register index 0 reads as zero inside the stage, whatever value is supplied for it, and writes aimed at index 0 are suppressed. An opcode or function code outside the set raises an illegal-instruction flag and blocks the write. Memory access, branches, the register file and overflow traps belong to other blocks.

Top module: `insn_exec_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_valid, wr_en and illegal are 0 and result and dest_idx are 0.
- R2: The stage has one cycle of latency: out_valid equals in_valid of the previous cycle, and when out_valid is 0 both wr_en and illegal are 0.
- R3: With opcode [31:26] equal to 0, function code [5:0] 32 gives rs + rt and 34 gives rs - rt, both modulo 2^32, written to rd [15:11]. Source fields are rs [25:21] and rt [20:16].
- R4: Function codes 36, 37 and 39 give the bitwise AND, OR and NOR of rs and rt; NOR with a zero operand gives the bitwise inverse of the other.
- R5: Function code 42 writes 1 when rs is less than rt as signed two's complement numbers, otherwise 0.
- R6: Function code 0 shifts rt left and code 2 shifts rt right, both by the 5-bit count in [10:6] and with zero fill.
- R7: Opcode 8 adds the sign-extended 16-bit immediate [15:0] to rs; immediate-form results go to rt [20:16].
- R8: Opcodes 12 and 13 give the AND and the OR of rs with the zero-extended immediate.
- R9: Opcode 15 places the immediate in result bits 31:16 and clears bits 15:0, ignoring the rs value.
- R10: A source field of 0 reads as 0 regardless of the register value supplied on that port.
- R11: An instruction whose destination index is 0 produces wr_en 0 and illegal 0.
- R12: Any other opcode, or opcode 0 with any other function code, gives illegal 1, wr_en 0, result 0 and dest_idx 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word and operands are present this cycle |
| instr | input | 32 | Instruction word |
| rs_val | input | DATA_W | Value of the register named by bits 25:21 |
| rt_val | input | DATA_W | Value of the register named by bits 20:16 |
| out_valid | output | 1 | Registered result is present |
| result | output | DATA_W | Operation result |
| dest_idx | output | 5 | Destination register index |
| wr_en | output | 1 | Register file write enable |
| illegal | output | 1 | Unrecognised opcode or function code |

## Verification
The bench builds the stage with its default DATA_W of 32, the width the fixed instruction format and its 5-bit shift count are defined for. At that width the carry out of bit 31, the sign bit that decides slt, a shift count of 31 and the upper half that lui writes all land on real port bits. A stream of back-to-back instructions with one idle gap exercises the one-cycle latency and the gating of wr_en and illegal on the same outputs.

// File: rtl/insn_exec_pkg.sv
package insn_exec_pkg;

    localparam int INSN_W  = 32;
    localparam int IDX_W   = 5;
    localparam int FIELD_W = 6;
    localparam int IMM_W   = 16;

    localparam logic [FIELD_W-1:0] OPC_REG  = 6'd0;
    localparam logic [FIELD_W-1:0] OPC_ADDI = 6'd8;
    localparam logic [FIELD_W-1:0] OPC_ANDI = 6'd12;
    localparam logic [FIELD_W-1:0] OPC_ORI  = 6'd13;
    localparam logic [FIELD_W-1:0] OPC_LUI  = 6'd15;

    localparam logic [FIELD_W-1:0] FN_SLL = 6'd0;
    localparam logic [FIELD_W-1:0] FN_SRL = 6'd2;
    localparam logic [FIELD_W-1:0] FN_ADD = 6'd32;
    localparam logic [FIELD_W-1:0] FN_SUB = 6'd34;
    localparam logic [FIELD_W-1:0] FN_AND = 6'd36;
    localparam logic [FIELD_W-1:0] FN_OR  = 6'd37;
    localparam logic [FIELD_W-1:0] FN_NOR = 6'd39;
    localparam logic [FIELD_W-1:0] FN_SLT = 6'd42;

    typedef enum logic [3:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_NOR,
        ALU_SLT,
        ALU_SHL,
        ALU_SHR,
        ALU_UPPER,
        ALU_NONE
    } alu_sel_e;

    typedef enum logic [1:0] {
        BSRC_REG,
        BSRC_SEXT,
        BSRC_ZEXT
    } bsrc_e;

    typedef struct packed {
        logic [FIELD_W-1:0] opc;
        logic [IDX_W-1:0]   src_a;
        logic [IDX_W-1:0]   src_b;
        logic [IDX_W-1:0]   dst_r;
        logic [IDX_W-1:0]   shamt;
        logic [FIELD_W-1:0] fn;
    } reg_fmt_t;

endpackage

// File: rtl/insn_decoder.sv
module insn_decoder
    import insn_exec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [INSN_W-1:0] instr,
    input  logic [DATA_W-1:0] rs_val,
    input  logic [DATA_W-1:0] rt_val,
    output alu_sel_e          alu_sel,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b,
    output logic [IDX_W-1:0]  shift_cnt,
    output logic [IDX_W-1:0]  dest,
    output logic              dest_live,
    output logic              bad_code
);

    localparam int EXT_W = DATA_W - IMM_W;

    reg_fmt_t         fld;
    logic [IMM_W-1:0] imm;
    bsrc_e            bsrc;
    logic             imm_form;
    logic [DATA_W-1:0] a_rd;
    logic [DATA_W-1:0] b_rd;

    always_comb begin
        fld      = reg_fmt_t'(instr);
        imm      = instr[IMM_W-1:0];
        alu_sel  = ALU_NONE;
        bsrc     = BSRC_REG;
        imm_form = 1'b0;
        bad_code = 1'b0;

        unique case (fld.opc)
            OPC_REG: begin
                unique case (fld.fn)
                    FN_ADD:  alu_sel = ALU_ADD;
                    FN_SUB:  alu_sel = ALU_SUB;
                    FN_AND:  alu_sel = ALU_AND;
                    FN_OR:   alu_sel = ALU_OR;
                    FN_NOR:  alu_sel = ALU_NOR;
                    FN_SLT:  alu_sel = ALU_SLT;
                    FN_SLL:  alu_sel = ALU_SHL;
                    FN_SRL:  alu_sel = ALU_SHR;
                    default: bad_code = 1'b1;
                endcase
            end
            OPC_ADDI: begin
                alu_sel  = ALU_ADD;
                bsrc     = BSRC_SEXT;
                imm_form = 1'b1;
            end
            OPC_ANDI: begin
                alu_sel  = ALU_AND;
                bsrc     = BSRC_ZEXT;
                imm_form = 1'b1;
            end
            OPC_ORI: begin
                alu_sel  = ALU_OR;
                bsrc     = BSRC_ZEXT;
                imm_form = 1'b1;
            end
            OPC_LUI: begin
                alu_sel  = ALU_UPPER;
                bsrc     = BSRC_ZEXT;
                imm_form = 1'b1;
            end
            default: bad_code = 1'b1;
        endcase

        a_rd = (fld.src_a == '0) ? '0 : rs_val;
        b_rd = (fld.src_b == '0) ? '0 : rt_val;

        opnd_a = a_rd;
        unique case (bsrc)
            BSRC_SEXT: opnd_b = {{EXT_W{imm[IMM_W-1]}}, imm};
            BSRC_ZEXT: opnd_b = {{EXT_W{1'b0}}, imm};
            default:   opnd_b = b_rd;
        endcase

        shift_cnt = fld.shamt;
        dest      = bad_code ? '0 : (imm_form ? fld.src_b : fld.dst_r);
        dest_live = !bad_code && (dest != '0);
    end

endmodule

// File: rtl/insn_alu.sv
module insn_alu
    import insn_exec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_sel_e          alu_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [IDX_W-1:0]  shift_cnt,
    output logic [DATA_W-1:0] alu_out
);

    localparam int HALF_W = DATA_W - IMM_W;

    logic signed [DATA_W-1:0] a_s;
    logic signed [DATA_W-1:0] b_s;

    always_comb begin
        a_s = opnd_a;
        b_s = opnd_b;
        unique case (alu_sel)
            ALU_ADD:   alu_out = opnd_a + opnd_b;
            ALU_SUB:   alu_out = opnd_a - opnd_b;
            ALU_AND:   alu_out = opnd_a & opnd_b;
            ALU_OR:    alu_out = opnd_a | opnd_b;
            ALU_NOR:   alu_out = ~(opnd_a | opnd_b);
            ALU_SLT:   alu_out = {{(DATA_W-1){1'b0}}, (a_s < b_s)};
            ALU_SHL:   alu_out = opnd_b << shift_cnt;
            ALU_SHR:   alu_out = opnd_b >> shift_cnt;
            ALU_UPPER: alu_out = {opnd_b[IMM_W-1:0], {HALF_W{1'b0}}};
            default:   alu_out = '0;
        endcase
    end

endmodule

// File: rtl/insn_exec_unit.sv
module insn_exec_unit
    import insn_exec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       instr,
    input  logic [DATA_W-1:0] rs_val,
    input  logic [DATA_W-1:0] rt_val,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic [4:0]        dest_idx,
    output logic              wr_en,
    output logic              illegal
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] res;
        logic [IDX_W-1:0]  dst;
        logic              we;
        logic              bad;
    } stage_t;

    alu_sel_e          alu_sel;
    logic [DATA_W-1:0] opnd_a;
    logic [DATA_W-1:0] opnd_b;
    logic [IDX_W-1:0]  shift_cnt;
    logic [IDX_W-1:0]  dest;
    logic              dest_live;
    logic              bad_code;
    logic [DATA_W-1:0] alu_out;

    stage_t stage_d;
    stage_t stage_q;

    insn_decoder #(.DATA_W(DATA_W)) u_dec (
        .instr     (instr),
        .rs_val    (rs_val),
        .rt_val    (rt_val),
        .alu_sel   (alu_sel),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .shift_cnt (shift_cnt),
        .dest      (dest),
        .dest_live (dest_live),
        .bad_code  (bad_code)
    );

    insn_alu #(.DATA_W(DATA_W)) u_alu (
        .alu_sel   (alu_sel),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .shift_cnt (shift_cnt),
        .alu_out   (alu_out)
    );

    always_comb begin
        stage_d = '0;
        if (in_valid) begin
            stage_d.valid = 1'b1;
            stage_d.res   = bad_code ? '0 : alu_out;
            stage_d.dst   = dest;
            stage_d.we    = dest_live;
            stage_d.bad   = bad_code;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid = stage_q.valid;
    assign result    = stage_q.res;
    assign dest_idx  = stage_q.dst;
    assign wr_en     = stage_q.we;
    assign illegal   = stage_q.bad;

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid && rst_n));

    assert_gated_by_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || illegal) |-> out_valid);

    assert_no_write_at_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (dest_idx != '0));

    assert_illegal_blocks_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!wr_en && result == '0));

    assert_upper_low_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && in_valid && instr[31:26] == OPC_LUI)
        |-> (result[IMM_W-1:0] == '0));

    assert_slt_boolean_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && in_valid && instr[31:26] == OPC_REG && instr[5:0] == FN_SLT)
        |-> (result[DATA_W-1:1] == '0));

endmodule

// File: tb/insn_exec_unit_tb.sv
module insn_exec_unit_tb;

    localparam int DW = 32;

    typedef struct {
        logic [DW-1:0] res;
        logic [4:0]    dst;
        logic          we;
        logic          bad;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [31:0]   instr = '0;
    logic [DW-1:0] rs_val = '0;
    logic [DW-1:0] rt_val = '0;
    logic          out_valid;
    logic [DW-1:0] result;
    logic [4:0]    dest_idx;
    logic          wr_en;
    logic          illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    insn_exec_unit #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .rs_val(rs_val), .rt_val(rt_val), .out_valid(out_valid),
        .result(result), .dest_idx(dest_idx), .wr_en(wr_en), .illegal(illegal)
    );

    function automatic logic [31:0] rfmt(int rs, int rt, int rd, int sh, int fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
    endfunction

    function automatic logic [31:0] ifmt(int op, int rs, int rt, logic [15:0] imm);
        return {6'(op), 5'(rs), 5'(rt), imm};
    endfunction

    function automatic exp_t model(logic [31:0] i, logic [DW-1:0] ra, logic [DW-1:0] rb, string tag);
        exp_t e;
        logic [DW-1:0] a, b, si, zi;
        logic ok;
        a  = (i[25:21] == 0) ? '0 : ra;
        b  = (i[20:16] == 0) ? '0 : rb;
        si = {{16{i[15]}}, i[15:0]};
        zi = {16'd0, i[15:0]};
        ok = 1'b1;
        e.res = '0;
        e.dst = i[15:11];
        e.tag = tag;
        case (i[31:26])
            0: case (i[5:0])
                32: e.res = a + b;
                34: e.res = a - b;
                36: e.res = a & b;
                37: e.res = a | b;
                39: e.res = ~(a | b);
                42: e.res = ($signed(a) < $signed(b)) ? 1 : 0;
                0:  e.res = b << i[10:6];
                2:  e.res = b >> i[10:6];
                default: ok = 1'b0;
            endcase
            8:  begin e.res = a + si; e.dst = i[20:16]; end
            12: begin e.res = a & zi; e.dst = i[20:16]; end
            13: begin e.res = a | zi; e.dst = i[20:16]; end
            15: begin e.res = {i[15:0], 16'd0}; e.dst = i[20:16]; end
            default: ok = 1'b0;
        endcase
        if (!ok) begin
            e.res = '0;
            e.dst = '0;
        end
        e.bad = !ok;
        e.we  = ok && (e.dst != 0);
        return e;
    endfunction

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(logic [31:0] i, logic [DW-1:0] a, logic [DW-1:0] b, string tag);
        @(negedge clk);
        in_valid = 1'b1;
        instr    = i;
        rs_val   = a;
        rt_val   = b;
        exp_q.push_back(model(i, a, b, tag));
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        instr    = 32'hFFFF_FFFF;
        rs_val   = '1;
        rt_val   = '1;
    endtask

    // monitor: pops one expected item per valid output
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected out_valid", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.tag, " result"}, result, e.res);
                check({e.tag, " dest_idx"}, {27'd0, dest_idx}, {27'd0, e.dst});
                check({e.tag, " wr_en"}, {31'd0, wr_en}, {31'd0, e.we});
                check({e.tag, " illegal"}, {31'd0, illegal}, {31'd0, e.bad});
            end
        end else if (rst_n) begin
            if (wr_en || illegal) check("R2 flags while idle", {30'd0, wr_en, illegal}, 0);
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 out_valid in reset", {31'd0, out_valid}, 0);
        check("R1 wr_en in reset", {31'd0, wr_en}, 0);
        check("R1 illegal in reset", {31'd0, illegal}, 0);
        check("R1 result in reset", result, 0);
        check("R1 dest_idx in reset", {27'd0, dest_idx}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", {31'd0, out_valid}, 0);

        drive(rfmt(5, 6, 7, 0, 32), 32'd7, 32'd9, "R3 add");
        drive(rfmt(5, 6, 7, 0, 32), 32'hFFFF_FFFF, 32'd1, "R3 add wrap");
        drive(rfmt(5, 6, 8, 0, 34), 32'd3, 32'd5, "R3 sub");
        drive(rfmt(10, 16, 3, 0, 36), 32'h0006_4078, 32'h0000_C80F, "R4 and");
        drive(rfmt(10, 16, 4, 0, 37), 32'h0006_4078, 32'h0000_C80F, "R4 or");
        drive(rfmt(10, 16, 5, 0, 39), 32'h0006_4078, 32'h0000_C80F, "R4 nor");
        drive(rfmt(10, 0, 5, 0, 39), 32'h1234_5678, 32'hFFFF_FFFF, "R4 nor as not");
        drive(rfmt(1, 2, 9, 0, 42), 32'hFFFF_FFFF, 32'd1, "R5 slt neg lt pos");
        drive(rfmt(1, 2, 9, 0, 42), 32'd1, 32'hFFFF_FFFF, "R5 slt pos vs neg");
        drive(rfmt(1, 2, 9, 0, 42), 32'd44, 32'd44, "R5 slt equal");
        idle();
        drive(rfmt(4, 18, 8, 3, 0), 32'hFFFF_FFFF, 32'h6000_C80F, "R6 sll 3");
        drive(rfmt(4, 18, 8, 31, 2), 32'd0, 32'h8000_0001, "R6 srl 31");
        drive(rfmt(4, 18, 8, 4, 2), 32'd0, 32'hF000_00F0, "R6 srl zero fill");
        drive(ifmt(8, 3, 11, 16'hFFFF), 32'd10, 32'hAAAA_AAAA, "R7 addi negative");
        drive(ifmt(8, 3, 12, 16'h7FFF), 32'd1, 32'd0, "R7 addi positive");
        drive(ifmt(12, 3, 13, 16'hFFFF), 32'hFFFF_1234, 32'd0, "R8 andi");
        drive(ifmt(13, 3, 14, 16'h8000), 32'h0000_0001, 32'd0, "R8 ori");
        drive(ifmt(15, 3, 15, 16'hABCD), 32'h5555_5555, 32'd0, "R9 lui");
        drive(ifmt(8, 0, 4, 16'd100), 32'hDEAD_BEEF, 32'd0, "R10 rs index zero");
        drive(rfmt(6, 0, 4, 0, 32), 32'd5, 32'hDEAD_BEEF, "R10 rt index zero");
        drive(rfmt(5, 6, 0, 0, 32), 32'd1, 32'd2, "R11 rd zero");
        drive(ifmt(13, 5, 0, 16'h00FF), 32'd1, 32'd0, "R11 rt dest zero");
        drive(rfmt(5, 6, 7, 0, 1), 32'd1, 32'd2, "R12 bad funct");
        drive(ifmt(63, 5, 7, 16'h1234), 32'd1, 32'd2, "R12 bad opcode");
        drive(ifmt(4, 5, 7, 16'h0001), 32'd1, 32'd1, "R12 branch opcode");
        idle();
        repeat (3) @(negedge clk);
        check("R2 all results delivered", exp_q.size(), 0);
        check("R2 idle out_valid", {31'd0, out_valid}, 0);
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #40000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule